// File: doc/BRIEF.md
# Piecewise-Linear Chaotic Map Iterator

This block produces a raw random bit stream by running a one-dimensional piecewise-linear chaotic map in fixed-point arithmetic. A signed state value `x` is stepped once on every clock on which the enable input is high. When `x` is negative, the new state is the lower slope times `x` plus an offset. When `x` is zero or positive, the new state is the upper slope times `x` minus the same offset. Each step emits the branch decision as a raw bit, together with a one-cycle valid strobe. Any debiasing of the stream is left to a stage further down.

The state uses a signed format with 2 integer bits and 14 fractional bits, so it covers [-2, 2). Both slopes are unsigned with 1 integer bit and 15 fractional bits. The offset uses the same format as the state. The slopes, the offset and the seed are captured only while reset is asserted. A seed of zero, or a seed that the map sends back onto itself, is swapped for a built-in default, because the stream would otherwise stop changing. For chaotic and bounded behaviour, both slopes should lie strictly between 1 and 2. The nominal setting is a common slope of 1.82 with an offset of 1.0, which gives a symmetric map and equal numbers of 0s and 1s.

A small state machine sequences the block. It has three states: `ST_LOAD`, `ST_STEP` and `ST_HOLD`.
- Every clock with reset high enters `ST_LOAD`.
- Out of reset, a clock with enable high enters `ST_STEP` from any state.
- Out of reset, a clock with enable low enters `ST_HOLD` from any state.
- The valid strobe is high only in `ST_STEP`.

Top module: `pwl_chaos_iter`

## Requirements
- R1: While `rst` is sampled high at a clock edge, `valid_o` is 0 and `bit_o` is 0 after that edge. This holds even if `en` is high at the same edge (reset wins), and the map state is reloaded.
- R2: At reset the state loads `seed_i`. The default `DEF_SEED` (16'h1A2B) is loaded instead when `seed_i` is 0, or when one map step on `seed_i` (using the input slopes and offset) returns `seed_i` unchanged.
- R3: When the state `x` is negative (bit 15 set), the next state is `sat(rnd(k_lo * x) + ofs)`.
- R4: When `x` is zero or positive, the next state is `sat(rnd(k_hi * x) - ofs)`.
- R5: On an enabled step, `bit_o` after the edge is 1 if `x` before the edge was zero or positive, and 0 if it was negative. Zero therefore counts as the upper branch.
- R6: `valid_o` after an edge equals `en` before it (with reset low), so exactly one strobe is produced per enabled clock. With `en` low, the state and `bit_o` hold their values.
- R7: The sum is saturated to the range [-32768, 32767] in raw units before it is stored. It never wraps.
- R8: After reset, changes on `k_lo_i`, `k_hi_i`, `ofs_i` and `seed_i` have no effect until the next reset.
- R9: `rnd` rounds half up. Work in raw units, with `x` in units of 2^-14 and the slope in units of 2^-15: the result is `floor((x*k + 2^14) / 2^15)`. For example, k = 1.5 and x = -1 lsb gives -1 lsb.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; captures the configuration |
| en | input | 1 | Step enable: one map step per clock while high |
| k_lo_i | input | 16 | Slope for negative state, unsigned Q1.15 |
| k_hi_i | input | 16 | Slope for zero or positive state, unsigned Q1.15 |
| ofs_i | input | 16 | Offset, signed Q2.14 |
| seed_i | input | 16 | Initial state, signed Q2.14 |
| bit_o | output | 1 | Raw bit of the latest step |
| valid_o | output | 1 | One-cycle strobe marking a new raw bit |

## Verification
Reset and a step request can land on the same edge. The bench provokes this by holding `en` high while it raises `rst` in the middle of a running sequence. It then judges that no strobe follows and that the first bit after release comes from the freshly loaded seed, not from the old trajectory. A second overlap occurs during reset itself: seed screening runs on the same inputs that are being captured. It is exercised with seeds at exact fixed points of the map, and the bench checks that the stream matches the default seed. Random slopes, offsets, seeds and enable gaps are compared bit by bit against a reference model in the bench. Saturation corners are driven directly.

// File: rtl/pwl_chaos_pkg.sv
package pwl_chaos_pkg;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_STEP = 2'd1,
        ST_HOLD = 2'd2
    } it_state_e;

endpackage

// File: rtl/pwl_branch_mac.sv
module pwl_branch_mac #(
    parameter int XW = 16,
    parameter int KW = 16,
    parameter int KF = 15
) (
    input  logic signed [XW-1:0] x_i,
    input  logic        [KW-1:0] k_lo_i,
    input  logic        [KW-1:0] k_hi_i,
    input  logic signed [XW-1:0] ofs_i,
    output logic signed [XW-1:0] nxt_o
);
    localparam int PW = XW + KW + 1;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (KF - 1);
    localparam logic signed [PW-1:0] SMAX = (PW'(1) <<< (XW - 1)) - PW'(1);
    localparam logic signed [PW-1:0] SMIN = -(PW'(1) <<< (XW - 1));

    logic                 neg;
    logic        [KW-1:0] k_sel;
    logic signed [PW-1:0] x_ext, k_ext, prod, shifted, ofs_ext, sum;

    always_comb begin
        neg     = x_i[XW-1];
        k_sel   = neg ? k_lo_i : k_hi_i;
        x_ext   = {{(PW-XW){x_i[XW-1]}}, x_i};
        k_ext   = {{(PW-KW){1'b0}}, k_sel};
        prod    = x_ext * k_ext;
        shifted = (prod + HALF) >>> KF;
        ofs_ext = {{(PW-XW){ofs_i[XW-1]}}, ofs_i};
        sum     = neg ? (shifted + ofs_ext) : (shifted - ofs_ext);
        if (sum > SMAX) begin
            nxt_o = SMAX[XW-1:0];
        end else if (sum < SMIN) begin
            nxt_o = SMIN[XW-1:0];
        end else begin
            nxt_o = sum[XW-1:0];
        end
    end
endmodule

// File: rtl/pwl_seed_guard.sv
module pwl_seed_guard #(
    parameter int XW = 16,
    parameter int KW = 16,
    parameter int KF = 15,
    parameter logic signed [XW-1:0] DEF_SEED = 16'sh1A2B
) (
    input  logic signed [XW-1:0] seed_i,
    input  logic        [KW-1:0] k_lo_i,
    input  logic        [KW-1:0] k_hi_i,
    input  logic signed [XW-1:0] ofs_i,
    output logic signed [XW-1:0] seed_o
);
    logic signed [XW-1:0] probe;
    logic                 stuck;

    pwl_branch_mac #(.XW(XW), .KW(KW), .KF(KF)) probe_i (
        .x_i    (seed_i),
        .k_lo_i (k_lo_i),
        .k_hi_i (k_hi_i),
        .ofs_i  (ofs_i),
        .nxt_o  (probe)
    );

    always_comb begin
        stuck  = (seed_i == '0) || (probe == seed_i);
        seed_o = stuck ? DEF_SEED : seed_i;
    end
endmodule

// File: rtl/pwl_chaos_ctrl.sv
module pwl_chaos_ctrl
    import pwl_chaos_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic step_o,
    output logic valid_o
);
    it_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOAD;
        end else if (en) begin
            state_q <= ST_STEP;
        end else begin
            state_q <= ST_HOLD;
        end
    end

    always_comb begin
        step_o = en && !rst;
        unique case (state_q)
            ST_LOAD: valid_o = 1'b0;
            ST_STEP: valid_o = 1'b1;
            ST_HOLD: valid_o = 1'b0;
            default: valid_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwl_chaos_iter.sv
module pwl_chaos_iter #(
    parameter int XW = 16,
    parameter int KW = 16,
    parameter int KF = 15,
    parameter logic signed [XW-1:0] DEF_SEED = 16'sh1A2B
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic        [KW-1:0] k_lo_i,
    input  logic        [KW-1:0] k_hi_i,
    input  logic signed [XW-1:0] ofs_i,
    input  logic signed [XW-1:0] seed_i,
    output logic                 bit_o,
    output logic                 valid_o
);
    localparam int SIGN = XW - 1;

    logic        [KW-1:0] k1_q, k2_q;
    logic signed [XW-1:0] q_q, x_q, x_nxt, seed_eff;
    logic                 bit_q, step;

    pwl_chaos_ctrl ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .step_o  (step),
        .valid_o (valid_o)
    );

    pwl_seed_guard #(.XW(XW), .KW(KW), .KF(KF), .DEF_SEED(DEF_SEED)) guard_i (
        .seed_i (seed_i),
        .k_lo_i (k_lo_i),
        .k_hi_i (k_hi_i),
        .ofs_i  (ofs_i),
        .seed_o (seed_eff)
    );

    pwl_branch_mac #(.XW(XW), .KW(KW), .KF(KF)) mac_i (
        .x_i    (x_q),
        .k_lo_i (k1_q),
        .k_hi_i (k2_q),
        .ofs_i  (q_q),
        .nxt_o  (x_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            k1_q  <= k_lo_i;
            k2_q  <= k_hi_i;
            q_q   <= ofs_i;
            x_q   <= seed_eff;
            bit_q <= 1'b0;
        end else if (step) begin
            x_q   <= x_nxt;
            bit_q <= ~x_q[SIGN];
        end
    end

    assign bit_o = bit_q;
endmodule

// File: rtl/pwl_chaos_chk.sv
module pwl_chaos_chk #(
    parameter int XW = 16,
    parameter int KW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic                 bit_o,
    input logic                 valid_o,
    input logic signed [XW-1:0] x_q,
    input logic        [KW-1:0] k1_q,
    input logic        [KW-1:0] k2_q,
    input logic signed [XW-1:0] q_q
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!valid_o && !bit_o));

    assert_seed_nonzero_R2: assert property (@(posedge clk)
        rst |=> (x_q != '0));

    assert_bit_sign_R5: assert property (@(posedge clk) disable iff (rst)
        en |=> (bit_o == !$past(x_q[XW-1])));

    assert_strobe_on_R6: assert property (@(posedge clk) disable iff (rst)
        en |=> valid_o);

    assert_strobe_off_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> !valid_o);

    assert_hold_state_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(x_q) && $stable(bit_o)));

    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($stable(k1_q) && $stable(k2_q) && $stable(q_q)));
endmodule

bind pwl_chaos_iter pwl_chaos_chk #(.XW(XW), .KW(KW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .bit_o   (bit_o),
    .valid_o (valid_o),
    .x_q     (x_q),
    .k1_q    (k1_q),
    .k2_q    (k2_q),
    .q_q     (q_q)
);

// File: tb/pwl_chaos_iter_tb_top.sv
module pwl_chaos_iter_tb_top;
    localparam logic signed [15:0] DEF = 16'sh1A2B;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en  = 1'b0;
    logic        [15:0] k1 = '0, k2 = '0;
    logic signed [15:0] q = '0, seed = '0;
    logic               bit_o, valid_o;

    int     total = 0, bad = 0;
    bit     done = 1'b0;
    longint mx, mk1, mk2, mq;
    logic   exp_bit;

    always #5 clk = ~clk;

    pwl_chaos_iter #(.DEF_SEED(DEF)) dut_i (
        .clk(clk), .rst(rst), .en(en), .k_lo_i(k1), .k_hi_i(k2),
        .ofs_i(q), .seed_i(seed), .bit_o(bit_o), .valid_o(valid_o)
    );

    function automatic longint f_next(longint x, longint a, longint b, longint o);
        longint p;
        p = (x < 0) ? x * a : x * b;
        p = (p + 16384) >>> 15;
        p = (x < 0) ? p + o : p - o;
        if (p > 32767) p = 32767;
        if (p < -32768) p = -32768;
        return p;
    endfunction

    function automatic longint f_guard(longint s, longint a, longint b, longint o);
        if (s == 0 || f_next(s, a, b, o) == s) return longint'(DEF);
        return s;
    endfunction

    task automatic check(bit ok, string req, longint act, longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic start(longint s, longint a, longint b, longint o, bit en_rst);
        @(negedge clk);
        rst = 1'b1; en = en_rst;
        seed = s[15:0]; k1 = a[15:0]; k2 = b[15:0]; q = o[15:0];
        mk1 = a; mk2 = b; mq = o;
        mx = f_guard(s, a, b, o);
        repeat (2) @(negedge clk);
        check(valid_o == 1'b0, "R1 valid in reset", valid_o, 0);
        check(bit_o == 1'b0, "R1 bit in reset", bit_o, 0);
        exp_bit = 1'b0;
        rst = 1'b0;
    endtask

    task automatic step(bit e, string req);
        en = e;
        @(negedge clk);
        check(valid_o == e, "R6 strobe", valid_o, e);
        if (e) begin
            exp_bit = (mx >= 0);
            check(bit_o == exp_bit, req, bit_o, exp_bit);
            mx = f_next(mx, mk1, mk2, mq);
        end else begin
            check(bit_o == exp_bit, "R6 hold bit", bit_o, exp_bit);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd4711));

        // R9: k=1.5, x=-1 lsb rounds to -1, plus 1 -> 0; alternates 0,1
        start(-1, 49152, 49152, 1, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b1, "R9 round half up");

        // R2: zero seed replaced by default
        start(0, 59638, 59638, 16384, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b1, "R2 zero seed");

        // R2: exact fixed points +1.0 and -1.0 with k=1.5, ofs=0.5
        start(16384, 49152, 49152, 8192, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b1, "R2 fixed point upper");
        start(-16384, 49152, 49152, 8192, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b1, "R2 fixed point lower");

        // R3/R4/R5: nominal symmetric map
        start(5000, 59638, 59638, 16384, 1'b0);
        for (int i = 0; i < 64; i++) step(1'b1, (mx < 0) ? "R3 lower branch" : "R4 upper branch");

        // R5: state exactly zero counts as upper branch (seed -1 path reaches 0)
        start(-1, 49152, 49152, 1, 1'b0);
        step(1'b1, "R5 negative gives 0");
        step(1'b1, "R5 zero gives 1");

        // R7: saturation at both ends
        start(-20000, 65535, 65535, 0, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b1, "R7 saturate low");
        start(20000, 65535, 65535, -8192, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b1, "R7 saturate high");

        // R6: random enable gaps
        start(-7000, 60000, 58000, 15000, 1'b0);
        for (int i = 0; i < 60; i++) step(1'($urandom_range(0, 1)), "R6 gapped step");

        // R8: inputs change after reset without effect
        start(3333, 59638, 57000, 16384, 1'b0);
        for (int i = 0; i < 40; i++) begin
            k1 = 16'($urandom); k2 = 16'($urandom);
            q = 16'($urandom); seed = 16'($urandom);
            step(1'b1, "R8 config ignored");
        end

        // R1: reset with enable high mid-run; reset wins
        for (int i = 0; i < 5; i++) step(1'b1, "R8 pre-collision");
        start(-4321, 59638, 59638, 16384, 1'b1);
        for (int i = 0; i < 20; i++) step(1'b1, "R1 after reset collision");

        // Random configurations
        for (int c = 0; c < 6; c++) begin
            longint a, b, o, s;
            a = 32769 + longint'($urandom_range(0, 32765));
            b = 32769 + longint'($urandom_range(0, 32765));
            o = 8192 + longint'($urandom_range(0, 16384));
            s = longint'($urandom_range(0, 49152)) - 24576;
            start(s, a, b, o, 1'($urandom_range(0, 1)));
            for (int i = 0; i < 50; i++)
                step(($urandom_range(0, 3) != 0), (mx < 0) ? "R3 random" : "R4 random");
        end

        summary();
    end
endmodule